// File: doc/BRIEF.md
# Transport Packet Resynchronizer and Parallel Framer

This block sits after a receive FIFO that holds transport stream bytes recovered from a serial link. It presents a byte stream at a fixed rate, one byte for each cycle in which `byte_en` is high, together with a packet-start strobe and a byte-valid strobe. Every output packet is `PKT_LEN` bytes long, 188 by default. A real packet is copied from the FIFO only when, at a packet boundary, the FIFO reports half-full and its head byte is the sync value 0x47. Otherwise a null packet is produced, so the output never pauses.

The FIFO is read in first-word-fall-through fashion. `fifo_data` shows the head byte whenever `fifo_empty` is low, and `fifo_rd` pops it on the same clock edge that consumes it. When a boundary check fails, the block loses lock. While it is unlocked, it discards every head byte that is not 0x47, one per enable, until a sync byte reaches the head. Real output then resumes at the next boundary.

Top module: `ts_resync_framer`

## Requirements
- R1: A synchronous active-high `rst` clears `ts_data`, `ts_start` and `ts_valid` to 0, holds `fifo_rd` low, and clears lock. The first enabled byte after reset is byte 0 of a packet.
- R2: A real packet starts only if `fifo_half` is high at the packet boundary. With it low, a null packet is sent and a locked block reads nothing.
- R3: When `fifo_half` is high, the FIFO is not empty and the head byte is 0x47 at a boundary, the block outputs that byte and the next `PKT_LEN`-1 FIFO bytes in order, popping one byte per enable.
- R4: Packets are exactly `PKT_LEN` enabled bytes long. `ts_start` is high for byte 0 only, and that byte is always 0x47.
- R5: A null packet is 0x47, 0x1F, 0xFF, 0x10, followed by 0xFF in every remaining position.
- R6: At a boundary where `fifo_half` is high and the head byte is not 0x47, the block discards that byte, loses lock and sends a null packet.
- R7: While unlocked and outside a real packet, each enable pops a head byte that is not 0x47. A 0x47 byte is never discarded.
- R8: While locked, a non-0x47 head with `fifo_half` low is neither read nor discarded, and null packets are sent.
- R9: `ts_valid` is high for exactly the clock after each enabled cycle. With `byte_en` low, `fifo_rd` stays low and `ts_data` holds its value.
- R10: If the FIFO runs empty inside a real packet, each missing byte is sent as 0xFF without a read, and the packet keeps its full length.
- R11: `fifo_rd` is never high while `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_en | input | 1 | Output byte rate enable |
| fifo_half | input | 1 | FIFO half-full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_data | input | 8 | FIFO head byte, first-word fall-through |
| fifo_rd | output | 1 | FIFO pop, same cycle as consumption |
| ts_data | output | 8 | Output stream byte |
| ts_start | output | 1 | First byte of a packet |
| ts_valid | output | 1 | New byte present this clock |

## Verification
The assertions take for granted a first-word-fall-through FIFO whose `fifo_data` is the true head whenever `fifo_empty` is low. They also assume that a high `fifo_half` means at least one full packet is stored. The bench models the FIFO as an array with read and write indices and derives half-full from the fill level against 188. The one exception is the R10 scenario, which forces the flag high on purpose to create an underrun inside a packet. Stimulus changes only on falling edges, and every run lasts a whole number of packets, so the bench always knows the packet phase.

// File: rtl/ts_frm_pkg.sv
package ts_frm_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;

  typedef enum logic {PK_NULL = 1'b0, PK_REAL = 1'b1} pkt_kind_e;

  // Content of an empty transport packet at a given position.
  function automatic logic [BYTE_W-1:0] null_pkt_byte(input int unsigned idx);
    case (idx)
      0:       return 8'h47;
      1:       return 8'h1F;
      3:       return 8'h10;
      default: return FILL_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/ts_pkt_counter.sv
module ts_pkt_counter #(
  parameter int PKT_LEN = 188,
  localparam int CNT_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [CNT_W-1:0] pos,
  output logic             at_bound
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (adv) begin
      pos <= (pos == LAST) ? '0 : pos + 1'b1;
    end
  end

  assign at_bound = (pos == '0);

  // R4
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    pos <= LAST);

  // R4
  pos_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && pos == LAST) |=> (pos == '0));

endmodule

// File: rtl/ts_sync_ctrl.sv
module ts_sync_ctrl
  import ts_frm_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SYNC_VAL = 8'h47
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              at_bound,
  input  logic              fifo_half,
  input  logic              fifo_empty,
  input  logic [BYTE_W-1:0] fifo_data,
  output logic              fifo_rd,
  output logic              cur_real,
  output logic              use_fifo
);

  pkt_kind_e kind_q;
  logic      locked_q;

  logic hd_sync, head_ok, start_real, mismatch, in_real, hunting, drop;

  always_comb begin
    hd_sync    = (fifo_data == SYNC_VAL);
    head_ok    = fifo_half && !fifo_empty;
    start_real = at_bound && head_ok && hd_sync;
    mismatch   = at_bound && head_ok && !hd_sync;
    in_real    = !at_bound && (kind_q == PK_REAL);
    hunting    = !locked_q || mismatch;
    use_fifo   = start_real || (in_real && !fifo_empty);
    drop       = !in_real && !start_real && hunting && !fifo_empty && !hd_sync;
    cur_real   = start_real || in_real;
    fifo_rd    = adv && (use_fifo || drop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q   <= PK_NULL;
      locked_q <= 1'b0;
    end else if (adv) begin
      if (at_bound) kind_q <= start_real ? PK_REAL : PK_NULL;
      if (start_real)    locked_q <= 1'b1;
      else if (mismatch) locked_q <= 1'b0;
    end
  end

  // R11
  no_empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> !fifo_empty);

  // R7
  keep_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_rd && !cur_real) |-> (fifo_data != SYNC_VAL));

  // R6
  lose_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && at_bound && fifo_half && !fifo_empty && fifo_data != SYNC_VAL)
      |=> (!locked_q && kind_q == PK_NULL));

endmodule

// File: rtl/ts_out_stage.sv
module ts_out_stage
  import ts_frm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter logic [BYTE_W-1:0] SYNC_VAL = 8'h47
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [CNT_W-1:0]  pos,
  input  logic              at_bound,
  input  logic              cur_real,
  input  logic              use_fifo,
  input  logic [BYTE_W-1:0] fifo_data,
  output logic [BYTE_W-1:0] ts_data,
  output logic              ts_start,
  output logic              ts_valid
);

  logic [BYTE_W-1:0] nxt_byte;

  always_comb begin
    if (use_fifo)      nxt_byte = fifo_data;
    else if (cur_real) nxt_byte = FILL_BYTE;
    else               nxt_byte = null_pkt_byte(int'(pos));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_data  <= '0;
      ts_start <= 1'b0;
      ts_valid <= 1'b0;
    end else begin
      ts_valid <= adv;
      ts_start <= adv && at_bound;
      if (adv) ts_data <= nxt_byte;
    end
  end

  // R4
  start_sync_chk: assert property (@(posedge clk) disable iff (rst)
    ts_start |-> (ts_valid && ts_data == SYNC_VAL));

endmodule

// File: rtl/ts_resync_framer.sv
module ts_resync_framer
  import ts_frm_pkg::*;
#(
  parameter int PKT_LEN = 188,
  parameter logic [7:0] SYNC_VAL = 8'h47
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_en,
  input  logic       fifo_half,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_data,
  output logic       fifo_rd,
  output logic [7:0] ts_data,
  output logic       ts_start,
  output logic       ts_valid
);

  localparam int CNT_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;

  logic             adv;
  logic [CNT_W-1:0] pos;
  logic             at_bound, cur_real, use_fifo;

  assign adv = byte_en && !rst;

  ts_pkt_counter #(.PKT_LEN(PKT_LEN)) cnt_i (
    .clk(clk), .rst(rst), .adv(adv), .pos(pos), .at_bound(at_bound)
  );

  ts_sync_ctrl #(.SYNC_VAL(SYNC_VAL)) ctrl_i (
    .clk(clk), .rst(rst), .adv(adv), .at_bound(at_bound),
    .fifo_half(fifo_half), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_rd(fifo_rd), .cur_real(cur_real), .use_fifo(use_fifo)
  );

  ts_out_stage #(.CNT_W(CNT_W), .SYNC_VAL(SYNC_VAL)) out_i (
    .clk(clk), .rst(rst), .adv(adv), .pos(pos), .at_bound(at_bound),
    .cur_real(cur_real), .use_fifo(use_fifo), .fifo_data(fifo_data),
    .ts_data(ts_data), .ts_start(ts_start), .ts_valid(ts_valid)
  );

  // R4
  pkt_start_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && at_bound) |=> ts_start);

  // R9
  valid_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !byte_en |=> (!ts_valid && $stable(ts_data)));

  // R9
  idle_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    !byte_en |-> !fifo_rd);

  // R2
  half_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && at_bound && !fifo_half) |-> !use_fifo);

endmodule

// File: tb/ts_resync_framer_tb.sv
module ts_resync_framer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PL = 188;
  localparam int HALF_LVL = 188;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_en = 1'b1;
  logic fifo_half, fifo_empty, fifo_rd, ts_start, ts_valid;
  logic [7:0] fifo_data, ts_data;

  logic [7:0] mem [0:4095];
  int wp = 0;
  int rp = 0;
  bit force_half = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] cap_d[$];
  bit         cap_s[$];
  logic [7:0] exp_d[$];
  bit         exp_s[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fifo_empty = (wp == rp);
  assign fifo_data  = mem[rp];
  assign fifo_half  = ((wp - rp) >= HALF_LVL) || force_half;

  always @(posedge clk) if (fifo_rd && wp != rp) rp <= rp + 1;

  ts_resync_framer dut_i (
    .clk(clk), .rst(rst), .byte_en(byte_en), .fifo_half(fifo_half),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
    .ts_data(ts_data), .ts_start(ts_start), .ts_valid(ts_valid)
  );

  function automatic logic [7:0] pkt_byte(int tag, int i);
    if (i == 0) return 8'h47;
    return 8'((tag * 13 + i * 3) ^ 8'hA5);
  endfunction

  function automatic logic [7:0] null_byte(int i);
    if (i == 0) return 8'h47;
    if (i == 1) return 8'h1F;
    if (i == 3) return 8'h10;
    return 8'hFF;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic push(logic [7:0] b);
    mem[wp] = b;
    wp = wp + 1;
  endtask

  task automatic push_pkt(int tag, int from, int to);
    for (int i = from; i < to; i++) push(pkt_byte(tag, i));
  endtask

  task automatic exp_pkt(int tag);
    for (int i = 0; i < PL; i++) begin exp_d.push_back(pkt_byte(tag, i)); exp_s.push_back(i == 0); end
  endtask

  task automatic exp_null();
    for (int i = 0; i < PL; i++) begin exp_d.push_back(null_byte(i)); exp_s.push_back(i == 0); end
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(negedge clk);
      if (ts_valid) begin cap_d.push_back(ts_data); cap_s.push_back(ts_start); end
    end
  endtask

  task automatic compare(string req);
    int bad = -1;
    chk(cap_d.size() == exp_d.size(), req, "stream length", cap_d.size(), exp_d.size());
    for (int i = 0; i < exp_d.size() && i < cap_d.size(); i++)
      if (bad < 0 && (cap_d[i] !== exp_d[i] || cap_s[i] !== exp_s[i])) bad = i;
    if (bad >= 0)
      chk(1'b0, req, $sformatf("byte %0d data/start", bad),
          {cap_d[bad], 7'd0, cap_s[bad]}, {exp_d[bad], 7'd0, exp_s[bad]});
    else
      chk(1'b1, req, "stream content", 0, 0);
    cap_d.delete(); cap_s.delete(); exp_d.delete(); exp_s.delete();
  endtask

  // R1, R5, R4, R3: reset state, then first packet taken right after release
  task automatic t_reset();
    push_pkt(0, 0, PL);
    repeat (3) @(negedge clk);
    chk(ts_valid == 0 && ts_start == 0, "R1", "strobes in reset", {ts_valid, ts_start}, 0);
    chk(ts_data == 8'h00, "R1", "data in reset", ts_data, 0);
    chk(fifo_rd == 0 && (wp - rp) == PL, "R1", "fifo level in reset", wp - rp, PL);
    rst = 1'b0;
    run(2 * PL);
    exp_pkt(0); exp_null();
    compare("R1 R5 R4");
  endtask

  // R3, R4: two back-to-back real packets
  task automatic t_real_pair();
    push_pkt(1, 0, PL); push_pkt(2, 0, PL);
    run(2 * PL);
    exp_pkt(1); exp_pkt(2);
    compare("R3");
    chk(wp == rp, "R3", "fifo drained", wp - rp, 0);
  endtask

  // R2: no packet start below half-full
  task automatic t_half_gate();
    push_pkt(3, 0, 100);
    run(PL);
    exp_null();
    compare("R2");
    chk((wp - rp) == 100, "R2", "no read below half", wp - rp, 100);
    push_pkt(3, 100, PL);
    run(PL);
    exp_pkt(3);
    compare("R2");
  endtask

  // R6, R7: garbage ahead of a packet is discarded up to the sync byte
  task automatic t_hunt();
    push(8'h00); push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    push_pkt(4, 0, PL);
    run(PL);
    exp_null();
    compare("R6");
    chk((wp - rp) == PL, "R7", "level after hunt", wp - rp, PL);
    chk(mem[rp] == 8'h47, "R7", "sync byte kept", mem[rp], 8'h47);
    run(PL);
    exp_pkt(4);
    compare("R7");
  endtask

  // R6: corrupt byte after a counted packet
  task automatic t_corrupt_next();
    push_pkt(5, 0, PL);
    for (int i = 0; i < PL; i++) push(8'h12);
    run(2 * PL);
    exp_pkt(5); exp_null();
    compare("R6");
    chk(wp == rp, "R6", "corrupt bytes all dropped", wp - rp, 0);
  endtask

  // R8: locked block waits for half-full before judging the head
  task automatic t_locked_wait();
    push_pkt(6, 0, PL);
    run(PL);
    exp_pkt(6);
    compare("R8");
    for (int i = 0; i < 10; i++) push(8'h33);
    run(PL);
    exp_null();
    compare("R8");
    chk((wp - rp) == 10, "R8", "no discard while locked", wp - rp, 10);
    for (int i = 0; i < PL - 10; i++) push(8'h33);
    run(PL);
    exp_null();
    compare("R6");
    chk(wp == rp, "R6", "drained after mismatch", wp - rp, 0);
  endtask

  // R10: underrun inside a real packet
  task automatic t_short_underrun();
    push_pkt(7, 0, 10);
    force_half = 1'b1;
    run(PL);
    force_half = 1'b0;
    for (int i = 0; i < PL; i++) begin
      exp_d.push_back(i < 10 ? pkt_byte(7, i) : 8'hFF); exp_s.push_back(i == 0);
    end
    compare("R10");
    chk(wp == rp, "R10", "no extra reads", wp - rp, 0);
    run(PL);
    exp_null();
    compare("R10");
  endtask

  // R9: enable gaps
  task automatic t_enable_gaps();
    int bad_valid = 0;
    int bad_rd = 0;
    int bad_hold = 0;
    logic [7:0] last = ts_data;
    push_pkt(8, 0, PL);
    for (int c = 0; c < 2 * PL; c++) begin
      byte_en = (c % 2 == 0);
      #1;
      if (!byte_en && fifo_rd) bad_rd++;
      @(negedge clk);
      if (ts_valid != (c % 2 == 0)) bad_valid++;
      if (ts_valid) begin
        cap_d.push_back(ts_data); cap_s.push_back(ts_start); last = ts_data;
      end else if (ts_data != last) bad_hold++;
    end
    byte_en = 1'b1;
    chk(bad_valid == 0, "R9", "valid strobe mismatches", bad_valid, 0);
    chk(bad_rd == 0, "R9", "reads while disabled", bad_rd, 0);
    chk(bad_hold == 0, "R9", "data changed while disabled", bad_hold, 0);
    exp_pkt(8);
    compare("R9");
    chk(wp == rp, "R9", "fifo drained", wp - rp, 0);
  endtask

  initial begin
    t_reset();
    t_real_pair();
    t_half_gate();
    t_hunt();
    t_corrupt_next();
    t_locked_wait();
    t_short_underrun();
    t_enable_gaps();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule